// File: doc/BRIEF.md
# Two-Port Code Multiplexer for a Converter Front End

This block sits in front of a 10-bit converter core that has two parallel input ports, A and B. It turns them into one code stream at the full clock rate. Three mode pins pick the behaviour, and the block registers them on every clock.

The block has three modes:

- **Interleave mode.** A half-rate phase input marks the cycles on which both ports are loaded together. The port A word leaves the block first and the port B word on the next clock, so the output runs A0, B0, A1, B1.
- **Port A pass-through.** The block forwards port A on every clock.
- **Port B pass-through.** The block forwards port B on every clock.

In the two pass-through modes, the middle mode pin picks the port, and it can change on any clock. Any other pin combination is reserved: the output freezes and the valid flag drops.

A synchronous active-low reset sets the output to mid-scale and clears every stage. A valid flag tells the core when the pipeline of the current mode holds real samples.

Top module: `dual_port_code_mux`

## Requirements
- R1: The mode pins decode as follows (ctl1, ctl2, ctl3):
    - 0,1,0 selects interleave.
    - 1,0,0 selects port A pass-through.
    - 1,1,0 selects port B pass-through.
    - Every other combination is reserved.
- R2: In port A pass-through, the port A word sampled at clock edge k is on `code_out` after edge k+1.
- R3: The pass-through port is chosen by ctl2 as sampled at the same edge as the data. ctl2 may change on every clock, and each output word comes from the port that ctl2 named at that word's sampling edge.
- R4: In interleave, the port A word is sampled at an edge k where half_phase is sampled high. That word is on `code_out` after edge k+2, provided the pins selected interleave at edges k and k+1.
- R5: In interleave, the port B word sampled at that same edge k is on `code_out` after edge k+3. This holds when half_phase is low at edge k+1 and the pins selected interleave at edges k, k+1 and k+2.
- R6: Reserved pins sampled at edge k leave `code_out` unchanged after edge k+1 and drive `code_valid` low.
- R7: A clock edge with rst_n low sets `code_out` to 10'h200 and `code_valid` to 0 after that edge.
- R8: Pass-through pins sampled at edge k give `code_valid` high after edge k+1.
- R9: In interleave, `code_valid` stays low until the first port A word of a captured pair appears. It then stays high for as long as interleave is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| half_phase | input | 1 | Half-rate load phase for interleave mode; high marks a load edge |
| ctl1 | input | 1 | Mode pin 1 |
| ctl2 | input | 1 | Mode pin 2; also picks the pass-through port (high = B) |
| ctl3 | input | 1 | Mode pin 3; must be low for any non-reserved mode |
| port_a | input | 10 | Port A data word |
| port_b | input | 10 | Port B data word |
| code_out | output | 10 | Registered output code |
| code_valid | output | 1 | High when `code_out` carries a sample of the current mode |

## Verification
The assertions check the following on every cycle:
- the reset value;
- the one-clock forwarding of ports A and B;
- the frozen output under reserved pins;
- the two- and three-clock interleave latencies;
- the quiet valid flag when interleave starts on a low phase.

Only the bench scenarios can show the rest:
- the full A0, B0, A1, B1 ordering over long runs;
- the ctl2 select toggling on every clock;
- mode changes at random offsets against the phase;
- resets in mid-stream.

The bench covers these by comparing every cycle against a model built from sampled-input histories.

// File: rtl/dpcm_pkg.sv
// Shared types for the two-port code multiplexer.
// Assumes: mode pins are plain synchronous levels.
package dpcm_pkg;

    typedef enum logic [1:0] {
        MODE_RSV  = 2'd0,
        MODE_PASS = 2'd1,
        MODE_ILV  = 2'd2
    } mode_e;

    // Map the three mode pins onto a mode class (R1)
    function automatic mode_e decode_pins(input logic p1, input logic p2, input logic p3);
        mode_e m;
        if (p3) begin
            m = MODE_RSV;
        end else if (p1) begin
            m = MODE_PASS;
        end else if (p2) begin
            m = MODE_ILV;
        end else begin
            m = MODE_RSV;
        end
        return m;
    endfunction

endpackage

// File: rtl/dpcm_ctl.sv
// Control stage: registers the decoded mode, the pass-through select and
// the half-rate phase, and keeps a one-cycle-delayed copy of the phase.
// The delayed copy steers the interleave output between the A and B words.
// Assumes: half_phase toggles every clock while interleave is in use.
module dpcm_ctl
    import dpcm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  half_phase,
    input  logic  ctl1,
    input  logic  ctl2,
    input  logic  ctl3,
    output mode_e mode_q,
    output logic  sel_b_q,
    output logic  ph_q,
    output logic  ph_d1
);

    // Register the mode class, port select and phase history on every clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_RSV;
            sel_b_q <= 1'b0;
            ph_q    <= 1'b0;
            ph_d1   <= 1'b0;
        end else begin
            mode_q  <= decode_pins(ctl1, ctl2, ctl3);
            sel_b_q <= ctl2;
            ph_q    <= half_phase;
            ph_d1   <= ph_q;
        end
    end

endmodule

// File: rtl/dpcm_capture.sv
// Capture stage: samples both ports on every clock. In interleave mode it
// latches the pair on the registered load phase and flags that a pair is held.
// Assumes: mode_q and ph_q come from dpcm_ctl, one register after the pins.
module dpcm_capture
    import dpcm_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int NPORT  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CODE_W-1:0]    port_in [NPORT],
    input  mode_e                mode_q,
    input  logic                 ph_q,
    output logic [CODE_W-1:0]    word_q  [NPORT],
    output logic [CODE_W-1:0]    pair_q  [NPORT],
    output logic                 pair_valid
);

    localparam logic [CODE_W-1:0] ZERO_CODE = '0;

    logic load_pair;
    assign load_pair = (mode_q == MODE_ILV) && ph_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Sample port p on every clock
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[p] <= ZERO_CODE;
            end else begin
                word_q[p] <= port_in[p];
            end
        end

        // Latch port p into the pair register on a load edge
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pair_q[p] <= ZERO_CODE;
            end else if (load_pair) begin
                pair_q[p] <= word_q[p];
            end
        end
    end

    // Track whether a pair from the current interleave run is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_valid <= 1'b0;
        end else if (mode_q != MODE_ILV) begin
            pair_valid <= 1'b0;
        end else if (ph_q) begin
            pair_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/dpcm_out.sv
// Output stage: picks the next code for the current mode and registers it with
// its valid flag. Reserved mode freezes the code.
// Assumes: port index 0 is A and index 1 is B.
module dpcm_out
    import dpcm_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int NPORT  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  mode_e                mode_q,
    input  logic                 sel_b_q,
    input  logic                 ph_d1,
    input  logic [CODE_W-1:0]    word_q [NPORT],
    input  logic [CODE_W-1:0]    pair_q [NPORT],
    input  logic                 pair_valid,
    output logic [CODE_W-1:0]    code_out,
    output logic                 code_valid
);

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
    localparam int PORT_A = 0;
    localparam int PORT_B = 1;

    logic [CODE_W-1:0] next_code;
    logic              next_valid;

    // Choose the next code and its validity from the mode
    always_comb begin
        next_code  = code_out;
        next_valid = 1'b0;
        case (mode_q)
            MODE_PASS: begin
                next_code  = sel_b_q ? word_q[PORT_B] : word_q[PORT_A];
                next_valid = 1'b1;
            end
            MODE_ILV: begin
                next_code  = ph_d1 ? pair_q[PORT_A] : pair_q[PORT_B];
                next_valid = pair_valid;
            end
            default: begin
                next_code  = code_out;
                next_valid = 1'b0;
            end
        endcase
    end

    // Register the output code and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out   <= MID_CODE;
            code_valid <= 1'b0;
        end else begin
            code_out   <= next_code;
            code_valid <= next_valid;
        end
    end

endmodule

// File: rtl/dual_port_code_mux.sv
// Top of the two-port code multiplexer: control, capture and output stages.
// Assumes: synchronous active-low reset and a single clock domain.
module dual_port_code_mux
    import dpcm_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_phase,
    input  logic              ctl1,
    input  logic              ctl2,
    input  logic              ctl3,
    input  logic [CODE_W-1:0] port_a,
    input  logic [CODE_W-1:0] port_b,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid
);

    localparam int NPORT = 2;

    mode_e             mode_q;
    logic              sel_b_q;
    logic              ph_q;
    logic              ph_d1;
    logic [CODE_W-1:0] port_in [NPORT];
    logic [CODE_W-1:0] word_q  [NPORT];
    logic [CODE_W-1:0] pair_q  [NPORT];
    logic              pair_valid;

    assign port_in[0] = port_a;
    assign port_in[1] = port_b;

    dpcm_ctl i_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_phase (half_phase),
        .ctl1       (ctl1),
        .ctl2       (ctl2),
        .ctl3       (ctl3),
        .mode_q     (mode_q),
        .sel_b_q    (sel_b_q),
        .ph_q       (ph_q),
        .ph_d1      (ph_d1)
    );

    dpcm_capture #(.CODE_W(CODE_W), .NPORT(NPORT)) i_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_in    (port_in),
        .mode_q     (mode_q),
        .ph_q       (ph_q),
        .word_q     (word_q),
        .pair_q     (pair_q),
        .pair_valid (pair_valid)
    );

    dpcm_out #(.CODE_W(CODE_W), .NPORT(NPORT)) i_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_q     (mode_q),
        .sel_b_q    (sel_b_q),
        .ph_d1      (ph_d1),
        .word_q     (word_q),
        .pair_q     (pair_q),
        .pair_valid (pair_valid),
        .code_out   (code_out),
        .code_valid (code_valid)
    );

endmodule

// File: rtl/dpcm_chk.sv
// Checker for the two-port code multiplexer, observing only top-level ports.
// A value produced by edge k is seen at tick k+1, hence the ##2 delays below.
module dpcm_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              half_phase,
    input logic              ctl1,
    input logic              ctl2,
    input logic              ctl3,
    input logic [CODE_W-1:0] port_a,
    input logic [CODE_W-1:0] port_b,
    input logic [CODE_W-1:0] code_out,
    input logic              code_valid
);

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic pins_ilv, pins_pass_a, pins_pass_b, pins_rsv;
    assign pins_ilv    = !ctl1 &&  ctl2 && !ctl3;
    assign pins_pass_a =  ctl1 && !ctl2 && !ctl3;
    assign pins_pass_b =  ctl1 &&  ctl2 && !ctl3;
    assign pins_rsv    = !(pins_ilv || pins_pass_a || pins_pass_b);

    logic prev_rst_low;

    // Remember whether the previous edge was a reset edge
    always_ff @(posedge clk) begin
        prev_rst_low <= !rst_n;
        // R7
        if (prev_rst_low) begin
            reset_state_chk: assert (code_out == MID_CODE && !code_valid);
        end
    end

    // R2
    pass_a_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pins_pass_a |-> ##2 (code_out == $past(port_a, 2) && code_valid));

    // R3
    pass_b_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pins_pass_b |-> ##2 (code_out == $past(port_b, 2) && code_valid));

    // R6
    reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pins_rsv |-> ##2 ($stable(code_out) && !code_valid));

    // R4
    ilv_a_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_ilv && half_phase) ##1 pins_ilv
        |-> ##2 (code_out == $past(port_a, 3) && code_valid));

    // R5
    ilv_b_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_ilv && half_phase) ##1 (pins_ilv && !half_phase) ##1 pins_ilv
        |-> ##2 (code_out == $past(port_b, 4) && code_valid));

    // R9
    ilv_fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_ilv) ##1 (pins_ilv && !half_phase) |-> ##2 !code_valid);

endmodule

bind dual_port_code_mux dpcm_chk #(.CODE_W(CODE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_phase (half_phase),
    .ctl1       (ctl1),
    .ctl2       (ctl2),
    .ctl3       (ctl3),
    .port_a     (port_a),
    .port_b     (port_b),
    .code_out   (code_out),
    .code_valid (code_valid)
);

// File: tb/test_dual_port_code_mux.sv
`timescale 1ns/1ps
// Bench: drives inputs on the falling edge and records them at the rising edge.
// It predicts every output from the recorded histories and compares on each clock.
module test_dual_port_code_mux;

    localparam int W      = 10;
    localparam int HMAX   = 4096;
    localparam int M_RSV  = 0;
    localparam int M_PASS = 1;
    localparam int M_ILV  = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         half_phase;
    logic         ctl1, ctl2, ctl3;
    logic [W-1:0] port_a, port_b;
    logic [W-1:0] code_out;
    logic         code_valid;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    logic         h_rstl [HMAX];
    int           h_mode [HMAX];
    logic         h_sel  [HMAX];
    logic         h_ph   [HMAX];
    logic [W-1:0] h_a    [HMAX];
    logic [W-1:0] h_b    [HMAX];

    logic [W-1:0] m_out;
    bit           m_known;

    always #2 clk = ~clk;

    dual_port_code_mux #(.CODE_W(W)) i_dual_port_code_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_phase (half_phase),
        .ctl1       (ctl1),
        .ctl2       (ctl2),
        .ctl3       (ctl3),
        .port_a     (port_a),
        .port_b     (port_b),
        .code_out   (code_out),
        .code_valid (code_valid)
    );

    // Record the inputs seen at each rising edge
    always @(posedge clk) begin
        if (cyc < HMAX) begin
            h_rstl[cyc] = !rst_n;
            if (ctl3)                   h_mode[cyc] = M_RSV;
            else if (ctl1)              h_mode[cyc] = M_PASS;
            else if (ctl2)              h_mode[cyc] = M_ILV;
            else                        h_mode[cyc] = M_RSV;
            h_sel[cyc] = ctl2;
            h_ph[cyc]  = half_phase;
            h_a[cyc]   = port_a;
            h_b[cyc]   = port_b;
        end
        cyc = cyc + 1;
    end

    function automatic int eff_mode(int j);
        if (j < 0)     return M_RSV;
        if (h_rstl[j]) return M_RSV;
        return h_mode[j];
    endfunction

    function automatic bit eff_ph(int j);
        if (j < 0)     return 1'b0;
        if (h_rstl[j]) return 1'b0;
        return h_ph[j];
    endfunction

    task automatic check_val(string tag, logic [W-1:0] act, logic [W-1:0] exp, int n);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s edge %0d: code actual=%h expected=%h", tag, n, act, exp);
        end
    endtask

    task automatic check_vld(string tag, logic act, logic exp, int n);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s edge %0d: valid actual=%b expected=%b", tag, n, act, exp);
        end
    endtask

    // Predict the output after edge n and compare it with the design
    task automatic check_edge();
        int n = cyc - 1;
        int m;
        if (n < 0 || n >= HMAX) return;
        if (h_rstl[n]) begin
            check_val("R7", code_out, 10'h200, n);
            check_vld("R7", code_valid, 1'b0, n);
            m_out = 10'h200; m_known = 1;
            return;
        end
        m = eff_mode(n - 1);
        if (m == M_PASS) begin
            m_out   = h_sel[n-1] ? h_b[n-1] : h_a[n-1];
            m_known = 1;
            check_val(h_sel[n-1] ? "R3" : "R2", code_out, m_out, n);
            check_vld("R1,R8", code_valid, 1'b1, n);
        end else if (m == M_RSV) begin
            if (m_known) check_val("R6", code_out, m_out, n);
            check_vld("R6", code_valid, 1'b0, n);
        end else begin
            if (eff_ph(n-2) && eff_mode(n-2) == M_ILV) begin
                m_out = h_a[n-2]; m_known = 1;
                check_val("R4", code_out, m_out, n);
                check_vld("R1,R9", code_valid, 1'b1, n);
            end else if (eff_ph(n-3) && !eff_ph(n-2) &&
                         eff_mode(n-3) == M_ILV && eff_mode(n-2) == M_ILV) begin
                m_out = h_b[n-3]; m_known = 1;
                check_val("R5", code_out, m_out, n);
                check_vld("R9", code_valid, 1'b1, n);
            end else begin
                m_known = 0;
                check_vld("R9", code_valid, 1'b0, n);
            end
        end
    endtask

    // Check the previous edge, then drive the next set of inputs
    task automatic step(bit rst, bit p1, bit p2, bit p3);
        @(negedge clk);
        check_edge();
        rst_n      = !rst;
        ctl1       = p1;
        ctl2       = p2;
        ctl3       = p3;
        port_a     = W'($urandom);
        port_b     = W'($urandom);
        half_phase = !half_phase;
    endtask

    initial begin
        rst_n = 0; ctl1 = 0; ctl2 = 0; ctl3 = 0;
        port_a = '0; port_b = '0; half_phase = 0;
        m_out = 10'h200; m_known = 1;
        // R7: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
        // R2: port A pass-through
        for (int i = 0; i < 20; i++) step(0, 1, 0, 0);
        // R3: port B pass-through
        for (int i = 0; i < 10; i++) step(0, 1, 1, 0);
        // R3: ctl2 toggled every clock or at random
        for (int i = 0; i < 30; i++) step(0, 1, i[0], 0);
        for (int i = 0; i < 30; i++) step(0, 1, 1'($urandom), 0);
        // R6: reserved combinations
        for (int i = 0; i < 10; i++) begin
            logic [2:0] r;
            case (i % 5)
                0: r = 3'b000; 1: r = 3'b001; 2: r = 3'b011;
                3: r = 3'b101; default: r = 3'b111;
            endcase
            step(0, r[2], r[1], r[0]);
        end
        // R4/R5/R9: interleave entered at each phase
        for (int i = 0; i < 40; i++) step(0, 0, 1, 0);
        step(0, 1, 0, 0);
        for (int i = 0; i < 41; i++) step(0, 0, 1, 0);
        // Mixed modes with resets in mid-stream
        for (int s = 0; s < 150; s++) begin
            int len = 1 + int'($urandom % 12);
            int sel = int'($urandom % 5);
            for (int i = 0; i < len; i++) begin
                bit r = ($urandom % 60) == 0;
                case (sel)
                    0: step(r, 0, 1, 0);
                    1: step(r, 1, 0, 0);
                    2: step(r, 1, 1, 0);
                    3: step(r, 1, 1'($urandom), 0);
                    default: step(r, 1'($urandom), 1'($urandom), 1);
                endcase
            end
        end
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run state actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule